// File: doc/BRIEF.md
# Multi-Byte Symbol Scrambler for 8b/10b PCIe Links

This block whitens one, two or four 8-bit symbols per clock for a first- or second-generation PCI Express transmit lane before 8b/10b encoding. A 16-bit LFSR with the polynomial X^16 + X^5 + X^4 + X^3 + 1 supplies eight keystream bits per symbol. Four combinational stages are chained inside one cycle. Each stage takes the LFSR state that the symbol before it left behind, so every byte of a word is scrambled exactly as a serial scrambler would scramble it.

Control symbols shape the sequence. A comma symbol reloads the seed 16'hFFFF for the symbol that follows it. A skip symbol leaves the state untouched. Any other symbol advances the state by eight shifts. Only data symbols are XORed with the keystream. There are two more controls. A debug enable passes the data through unscrambled. A training-set bypass keeps the XOR off data bytes for ordered sets that must not be scrambled. In both cases the LFSR keeps stepping, so the sequence stays in step. The scrambled word, the K flags and the length code come out on registers, all one cycle after the input.

Top module: `scr_multibyte`

## Requirements
- R1: While reset is asserted, all outputs are zero. After reset is released, the LFSR state is 16'hFFFF, so the first data byte is XORed with 8'hFF.
- R2: Keystream bit i of a symbol is bit 15 of the state before shift i, applied to data bit i. After reset, zero data bytes scramble to FF, 17, C0, 14, B2, E7, 02, 82 in this order.
- R3: Byte k of the word is bits [8k+7:8k]. Byte 0 is the earliest symbol. Each byte uses the state left by byte k-1 of the same word. The state carries to the next cycle from the last valid byte.
- R4: A byte with its K flag set and the value 8'hBC (comma) is output unchanged. The byte after it, in the same or a later word, starts from state 16'hFFFF.
- R5: A byte with its K flag set and the value 8'h1C (skip) is output unchanged and does not advance the state.
- R6: A byte with its K flag set and any other value is output unchanged but advances the state by eight shifts.
- R7: Length code 2'b00 makes byte 0 valid, 2'b01 makes bytes 0 to 1 valid, and 2'b10 makes bytes 0 to 3 valid. Bytes above the valid range are output unchanged and do not touch the state.
- R8: Length code 2'b11 is treated as 2'b00, a single valid byte.
- R9: With the scramble enable low, every byte is output unchanged while the state advances as in normal operation.
- R10: With the training bypass high, data bytes are output unchanged while the state advances as in normal operation.
- R11: The K flag vector and the length code appear on their outputs one cycle after the input, aligned with the word they describe.
- R12: A byte whose value is 8'hBC or 8'h1C but whose K flag is clear is ordinary data: it is scrambled and advances the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 32 | Input symbols, byte 0 earliest |
| kflag_in | input | 4 | Per-byte control-symbol flags |
| len_in | input | 2 | Valid byte count code |
| scr_en | input | 1 | Scramble enable (debug) |
| ts_bypass | input | 1 | Suppress XOR on data bytes |
| sym_out | output | 32 | Scrambled symbols, registered |
| kflag_out | output | 4 | Forwarded K flags, registered |
| len_out | output | 2 | Forwarded length code, registered |

## Verification
The bench builds the block with its default parameters: four lanes, a 16-bit LFSR with seed FFFF, comma 8'hBC and skip 8'h1C. With four lanes, all three length codes and the reserved code are exercised. Commas and skips can land at every byte position, including mid-word reloads followed by data in the same cycle. Randomly chosen words mix the special values with and without K flags. This lets the chaining between stages, and the hand-off of state from the last valid byte, be compared with a serial bit-by-bit model over thousands of symbols.

// File: rtl/scr_pkg.sv
package scr_pkg;

   localparam int SYM_W = 8;
   localparam int LEN_W = 2;

   typedef enum logic [LEN_W-1:0] {
      LEN_ONE  = 2'b00,
      LEN_TWO  = 2'b01,
      LEN_FOUR = 2'b10,
      LEN_RSVD = 2'b11
   } len_code_e;

   // Number of valid lanes for a length code, clipped to the lane count.
   function automatic int lanes_of(input logic [LEN_W-1:0] code, input int max_lanes);
      int n;
      case (len_code_e'(code))
         LEN_TWO:  n = 2;
         LEN_FOUR: n = 4;
         default:  n = 1;
      endcase
      if (n > max_lanes) n = max_lanes;
      return n;
   endfunction

endpackage

// File: rtl/scr_lfsr_step.sv
// Advances a Galois-form LFSR by SHIFTS serial steps in one combinational pass,
// returning the keystream bit seen before each step.
module scr_lfsr_step #(
   parameter int          LFSR_W = 16,
   parameter logic [15:0] TAPS   = 16'h0038,
   parameter int          SHIFTS = 8
) (
   input  logic [LFSR_W-1:0] st_in,
   output logic [LFSR_W-1:0] st_adv,
   output logic [SHIFTS-1:0] key
);

   logic [LFSR_W-1:0] work;
   logic              fb;

   always_comb begin
      work = st_in;
      fb   = 1'b0;
      key  = '0;
      for (int i = 0; i < SHIFTS; i++) begin
         fb     = work[LFSR_W-1];
         key[i] = fb;
         work   = {work[LFSR_W-2:0], fb} ^ ({LFSR_W{fb}} & TAPS[LFSR_W-1:0]);
      end
      st_adv = work;
   end

endmodule

// File: rtl/scr_lane_mask.sv
// Turns the length code into a per-lane valid mask.
module scr_lane_mask
   import scr_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input  logic [LEN_W-1:0]     len_code,
   output logic [NUM_LANES-1:0] lane_valid
);

   int lane_cnt;

   always_comb lane_cnt = lanes_of(len_code, NUM_LANES);

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_mask
      assign lane_valid[k] = (k < lane_cnt);
   end

endmodule

// File: rtl/scr_byte_stage.sv
// One symbol lane: applies comma / skip / data rules and hands the state on.
module scr_byte_stage
   import scr_pkg::*;
#(
   parameter int                LFSR_W  = 16,
   parameter logic [15:0]       TAPS    = 16'h0038,
   parameter logic [LFSR_W-1:0] SEED    = 16'hFFFF,
   parameter logic [SYM_W-1:0]  COM_SYM = 8'hBC,
   parameter logic [SYM_W-1:0]  SKP_SYM = 8'h1C
) (
   input  logic [LFSR_W-1:0] st_in,
   input  logic [SYM_W-1:0]  sym,
   input  logic              is_k,
   input  logic              valid,
   input  logic              scr_en,
   input  logic              ts_bypass,
   output logic [LFSR_W-1:0] st_out,
   output logic [SYM_W-1:0]  sym_scr
);

   logic [LFSR_W-1:0] st_adv;
   logic [SYM_W-1:0]  key;
   logic              is_com;
   logic              is_skp;
   logic              do_xor;

   scr_lfsr_step #(
      .LFSR_W (LFSR_W),
      .TAPS   (TAPS),
      .SHIFTS (SYM_W)
   ) u_step (
      .st_in  (st_in),
      .st_adv (st_adv),
      .key    (key)
   );

   assign is_com = is_k && (sym == COM_SYM);
   assign is_skp = is_k && (sym == SKP_SYM);
   assign do_xor = valid && !is_k && scr_en && !ts_bypass;

   always_comb begin
      if (!valid)      st_out = st_in;
      else if (is_com) st_out = SEED;
      else if (is_skp) st_out = st_in;
      else             st_out = st_adv;
   end

   assign sym_scr = do_xor ? (sym ^ key) : sym;

endmodule

// File: rtl/scr_multibyte.sv
module scr_multibyte
   import scr_pkg::*;
#(
   parameter int          NUM_LANES = 4,
   parameter int          LFSR_W    = 16,
   parameter logic [15:0] TAPS      = 16'h0038,
   parameter logic [15:0] SEED      = 16'hFFFF,
   parameter logic [7:0]  COM_SYM   = 8'hBC,
   parameter logic [7:0]  SKP_SYM   = 8'h1C
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_LANES*SYM_W-1:0] sym_in,
   input  logic [NUM_LANES-1:0]       kflag_in,
   input  logic [LEN_W-1:0]           len_in,
   input  logic                       scr_en,
   input  logic                       ts_bypass,
   output logic [NUM_LANES*SYM_W-1:0] sym_out,
   output logic [NUM_LANES-1:0]       kflag_out,
   output logic [LEN_W-1:0]           len_out
);

   localparam int DATA_W = NUM_LANES * SYM_W;

   // Elaboration-time parameter checks
   if (!(NUM_LANES == 1 || NUM_LANES == 2 || NUM_LANES == 4)) begin : g_bad_lanes
      $error("scr_multibyte: NUM_LANES must be 1, 2 or 4");
   end
   if (LFSR_W < 2 || LFSR_W > 16) begin : g_bad_width
      $error("scr_multibyte: LFSR_W must be 2..16");
   end
   if (SEED[LFSR_W-1:0] == '0) begin : g_bad_seed
      $error("scr_multibyte: SEED must be non-zero");
   end
   if (COM_SYM == SKP_SYM) begin : g_bad_codes
      $error("scr_multibyte: comma and skip codes must differ");
   end

   logic [LFSR_W-1:0]    state_q;
   logic [LFSR_W-1:0]    chain [NUM_LANES+1];
   logic [NUM_LANES-1:0] lane_valid;
   logic [DATA_W-1:0]    sym_scr;

   scr_lane_mask #(.NUM_LANES(NUM_LANES)) u_mask (
      .len_code   (len_in),
      .lane_valid (lane_valid)
   );

   assign chain[0] = state_q;

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      scr_byte_stage #(
         .LFSR_W  (LFSR_W),
         .TAPS    (TAPS),
         .SEED    (SEED[LFSR_W-1:0]),
         .COM_SYM (COM_SYM),
         .SKP_SYM (SKP_SYM)
      ) u_stage (
         .st_in     (chain[k]),
         .sym       (sym_in[k*SYM_W +: SYM_W]),
         .is_k      (kflag_in[k]),
         .valid     (lane_valid[k]),
         .scr_en    (scr_en),
         .ts_bypass (ts_bypass),
         .st_out    (chain[k+1]),
         .sym_scr   (sym_scr[k*SYM_W +: SYM_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEED[LFSR_W-1:0];
         sym_out   <= '0;
         kflag_out <= '0;
         len_out   <= '0;
      end else begin
         state_q   <= chain[NUM_LANES];
         sym_out   <= sym_scr;
         kflag_out <= kflag_in;
         len_out   <= len_in;
      end
   end

endmodule

// File: rtl/scr_multibyte_chk.sv
module scr_multibyte_chk
   import scr_pkg::*;
#(
   parameter int NUM_LANES = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_LANES*SYM_W-1:0] sym_in,
   input logic [NUM_LANES-1:0]       kflag_in,
   input logic [LEN_W-1:0]           len_in,
   input logic                       scr_en,
   input logic                       ts_bypass,
   input logic [NUM_LANES*SYM_W-1:0] sym_out,
   input logic [NUM_LANES-1:0]       kflag_out,
   input logic [LEN_W-1:0]           len_out
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R11: side-band fields forwarded with one cycle of latency
   assert_side_fwd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (kflag_out == $past(kflag_in) && len_out == $past(len_in)));

   // R9: debug disable gives raw data
   assert_debug_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!scr_en)) |-> (sym_out == $past(sym_in)));

   // R10: training bypass gives raw data
   assert_bypass_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(ts_bypass)) |-> (sym_out == $past(sym_in)));

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane_chk
      // R6: control symbols are never XORed (covers comma R4 and skip R5 too)
      assert_k_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && kflag_out[k]) |->
            (sym_out[k*SYM_W +: SYM_W] == $past(sym_in[k*SYM_W +: SYM_W])));

      // R7: lanes above the valid range are untouched
      assert_unused_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && (k >= lanes_of(len_out, NUM_LANES))) |->
            (sym_out[k*SYM_W +: SYM_W] == $past(sym_in[k*SYM_W +: SYM_W])));
   end

endmodule

bind scr_multibyte scr_multibyte_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/sim_scr_multibyte.sv
module sim_scr_multibyte;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] sym_in = '0;
   logic [3:0]  kflag_in = '0;
   logic [1:0]  len_in = '0;
   logic        scr_en = 1'b1;
   logic        ts_bypass = 1'b0;
   logic [31:0] sym_out;
   logic [3:0]  kflag_out;
   logic [1:0]  len_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic [15:0] m_st = 16'hFFFF;

   always #(CLK_PERIOD/2) clk = ~clk;

   scr_multibyte u0 (
      .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .kflag_in(kflag_in),
      .len_in(len_in), .scr_en(scr_en), .ts_bypass(ts_bypass),
      .sym_out(sym_out), .kflag_out(kflag_out), .len_out(len_out)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   // Serial model: one byte through the scrambler rules, rotate-and-tap form.
   function automatic logic [7:0] model_byte(input logic [7:0] b, input logic k,
                                              input logic en, input logic byp);
      logic [7:0] ks;
      if (k && b == 8'hBC) begin
         m_st = 16'hFFFF;
         return b;
      end
      if (k && b == 8'h1C) return b;
      ks = '0;
      for (int i = 0; i < 8; i++) begin
         ks[i] = m_st[15];
         m_st  = {m_st[14:0], m_st[15]} ^ (m_st[15] ? 16'h0038 : 16'h0000);
      end
      return (k || !en || byp) ? b : (b ^ ks);
   endfunction

   function automatic logic [31:0] model_word(input logic [31:0] d, input logic [3:0] k,
                                               input logic [1:0] l, input logic en,
                                               input logic byp);
      logic [31:0] r;
      int cnt;
      cnt = (l == 2'b01) ? 2 : (l == 2'b10) ? 4 : 1;
      r = d;
      for (int j = 0; j < cnt; j++)
         r[j*8 +: 8] = model_byte(d[j*8 +: 8], k[j], en, byp);
      return r;
   endfunction

   // Drive one word at a falling edge, check the registered result one cycle later.
   task automatic step(input string req, input logic [31:0] d, input logic [3:0] k,
                       input logic [1:0] l, input logic en, input logic byp,
                       output logic [31:0] got);
      logic [31:0] exp;
      sym_in = d; kflag_in = k; len_in = l; scr_en = en; ts_bypass = byp;
      exp = model_word(d, k, l, en, byp);
      @(posedge clk);
      @(negedge clk);
      got = sym_out;
      check(req, sym_out, exp);
      check("R11 kflag", {28'd0, kflag_out}, {28'd0, k});
      check("R11 len", {30'd0, len_out}, {30'd0, l});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sym_in = 32'hDEADBEEF; kflag_in = 4'hF; len_in = 2'b10;
      scr_en = 1'b1; ts_bypass = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 reset data", sym_out, 32'h0);
      check("R1 reset side", {26'd0, kflag_out, len_out}, 32'h0);
      rst_n = 1'b1;
      m_st = 16'hFFFF;
   endtask

   initial begin
      logic [31:0] g;
      logic [7:0] seq [8] = '{8'hFF, 8'h17, 8'hC0, 8'h14, 8'hB2, 8'hE7, 8'h02, 8'h82};

      do_reset();
      // R1 / R2: single zero bytes after reset
      for (int i = 0; i < 8; i++) begin
         step("R2 byte stream", 32'h0, 4'h0, 2'b00, 1'b1, 1'b0, g);
         check("R2 known sequence", {24'd0, g[7:0]}, {24'd0, seq[i]});
      end

      // R3: four bytes per word, byte 0 earliest
      do_reset();
      step("R3 word4", 32'h0, 4'h0, 2'b10, 1'b1, 1'b0, g);
      check("R3 word4 first", g, 32'h14C017FF);
      step("R3 word4", 32'h0, 4'h0, 2'b10, 1'b1, 1'b0, g);
      check("R3 word4 second", g, 32'h8202E7B2);

      // R3: two bytes per word, state carried from byte 1
      do_reset();
      step("R3 word2", 32'h0, 4'h0, 2'b01, 1'b1, 1'b0, g);
      check("R3 word2 first", g, 32'h000017FF);
      step("R3 word2", 32'h0, 4'h0, 2'b01, 1'b1, 1'b0, g);
      check("R3 word2 second", g, 32'h000014C0);

      // R4: comma reloads the seed mid-stream
      do_reset();
      step("R4 prefix", 32'h0, 4'h0, 2'b10, 1'b1, 1'b0, g);
      step("R4 comma", 32'h000000BC, 4'b0001, 2'b10, 1'b1, 1'b0, g);
      check("R4 comma reseed", g, 32'hC017FFBC);
      step("R4 comma mid", 32'h0000BC00, 4'b0010, 2'b10, 1'b1, 1'b0, g);
      check("R4 comma mid-word", g, 32'h17FFBC14);

      // R5: skips hold the state
      do_reset();
      step("R5 skip", 32'h001C1C00, 4'b0110, 2'b10, 1'b1, 1'b0, g);
      check("R5 skip hold", g, 32'h171C1CFF);

      // R6: other control symbol advances without XOR
      do_reset();
      step("R6 kcode", 32'h000000F7, 4'b0001, 2'b10, 1'b1, 1'b0, g);
      check("R6 kcode advance", g, 32'h14C017F7);

      // R8 / R7: reserved length code acts as one byte; upper bytes untouched
      do_reset();
      step("R8 len11", 32'hAAAAAA00, 4'h0, 2'b11, 1'b1, 1'b0, g);
      check("R8 R7 len11 one byte", g, 32'hAAAAAAFF);
      step("R7 after", 32'h0, 4'h0, 2'b00, 1'b1, 1'b0, g);
      check("R7 state untouched", g, 32'h00000017);

      // R9: debug disable still advances
      do_reset();
      step("R9 disabled", 32'h0, 4'h0, 2'b10, 1'b0, 1'b0, g);
      check("R9 raw", g, 32'h0);
      step("R9 resume", 32'h0, 4'h0, 2'b00, 1'b1, 1'b0, g);
      check("R9 state advanced", g, 32'h000000B2);

      // R10: training bypass still advances
      do_reset();
      step("R10 bypass", 32'h0, 4'h0, 2'b10, 1'b1, 1'b1, g);
      check("R10 raw", g, 32'h0);
      step("R10 resume", 32'h0, 4'h0, 2'b00, 1'b1, 1'b0, g);
      check("R10 state advanced", g, 32'h000000B2);

      // R12: special values without K flag are data
      do_reset();
      step("R12 data bc", 32'h000000BC, 4'h0, 2'b00, 1'b1, 1'b0, g);
      check("R12 data bc scrambled", g, 32'h00000043);
      step("R12 data 1c", 32'h0000001C, 4'h0, 2'b00, 1'b1, 1'b0, g);
      check("R12 data 1c scrambled", g, 32'h0000000B);

      // Random mix, R3 R4 R5 R6 R7 R12 against the serial model
      do_reset();
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] d;
         logic [3:0]  k;
         logic [1:0]  l;
         logic        en, byp;
         d = $urandom();
         k = $urandom() & 4'hF;
         for (int j = 0; j < 4; j++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) d[j*8 +: 8] = 8'hBC;
            else if (r == 1) d[j*8 +: 8] = 8'h1C;
         end
         if ($urandom_range(0, 1) == 0) k = 4'h0;
         l = 2'($urandom_range(0, 3));
         en = ($urandom_range(0, 15) != 0);
         byp = ($urandom_range(0, 15) == 0);
         step("R3 random", d, k, l, en, byp, g);
      end

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule